// File: doc/BRIEF.md
# Circular Receive Packet Buffer Manager

This block stores incoming Ethernet frames in a byte-addressed RAM region that it treats as a ring. Software programs the first and last byte of the ring with `cfg_start` and `cfg_end`, both inclusive. Frame bytes arrive on a valid/ready byte stream, marked with start-of-frame, end-of-frame and error flags. Each frame is written as a 6-byte header followed by its bytes. The header gives the address where the next frame begins, the number of bytes the frame holds (the CRC bytes included, as delivered) and a status word. Once the header is written, the block moves its write pointer to the next-frame address and counts one more pending frame.

The host reads frames on its own port, which is outside this block. When it has finished with a frame it writes the frame's next-frame address into the read pointer, which frees that space. It pulses `host_pkt_dec` to take one frame off the pending count. If a frame does not fit in the free space, it is dropped whole: the write pointer stays where it was, no unread byte is touched, and the sticky `overflow` flag is set.

Back-pressure is simple. `s_ready` is high at all times except during the six header-writing cycles that follow an accepted end-of-frame byte. A byte transfers on a rising edge where `s_valid` and `s_ready` are both high. A source that is dropped still has every byte of its frame accepted. The configuration inputs must be held stable while the block is out of reset. The ring must start on an even address and hold an even number of bytes.

Top module: `rxring_buffer_mgr`

## Requirements
- R1: The ring wraps at the last configured address. The byte that follows the one written at `cfg_end` is written at `cfg_start`. This applies to frame bytes and header bytes alike.
- R2: `mem_we` is asserted only for addresses from `cfg_start` to `cfg_end` inclusive.
- R3: A stored frame with base address B has its header at B..B+5 and its bytes from B+6 onwards, in arrival order. The header bytes are, in order:
  - the next-frame address, low byte then high byte;
  - the byte count L, low byte then high byte;
  - the status word, low byte then high byte.
  Status bit 7 (bit 7 of byte B+4) is 1 when no byte of the frame carried `s_err`, and 0 otherwise. All other status bits are 0.
- R4: Let N = `cfg_end`-`cfg_start`+1 and free = (rd - wr - 1) mod N. A frame of L bytes is stored only if 6+L, rounded up to even, is no greater than free. Otherwise it is dropped: the write pointer and the pending count do not change, and no byte between the read and write pointers is written.
- R5: The next-frame address is B plus 6+L rounded up to even, wrapped into the ring. `wr_ptr` takes this value on the sixth rising edge after the edge that accepted the end-of-frame byte. `s_ready` is low for the cycles in between and high again afterwards.
- R6: The pending count rises by one when a frame is committed and falls by one on each cycle with `host_pkt_dec` high. When both happen in the same cycle, the count does not change. A decrement at zero has no effect.
- R7: The pending count saturates at 255.
- R8: `overflow` is set when a frame is dropped and stays set until reset.
- R9: Writing `host_rd_ptr` with `host_rd_we` moves the read pointer. The space this frees is available to the next frame.
- R10: Outside a frame, a byte without `s_sof` is accepted and discarded, with no memory write.
- R11: After reset, `wr_ptr` and the read pointer equal `cfg_start`, the count is 0, `overflow` is 0, `s_ready` is 1 and `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | AW | First ring address (even) |
| cfg_end | input | AW | Last ring address (inclusive) |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| s_err | input | 1 | Receive error seen on this byte |
| host_rd_we | input | 1 | Load the read pointer |
| host_rd_ptr | input | AW | New read pointer value |
| host_pkt_dec | input | 1 | Take one frame off the pending count |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| wr_ptr | output | AW | Hardware write pointer (base of next frame) |
| pkt_count | output | CNT_W | Pending frame count |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
Each accepted byte appears on the RAM write port one cycle after its accepting edge. The header bytes follow on the six cycles after the end-of-frame edge, and `wr_ptr` and the count change on the last of those six edges. A drop sets `overflow` on the end-of-frame edge itself. The bench drives inputs on falling edges and reads outputs on falling edges. In one directed frame it tracks every cycle of the header window and checks that `wr_ptr` changes on exactly the sixth edge. For the other frames it waits past that window before comparing RAM contents and pointers. A falling-edge monitor checks every RAM write against the ring bounds and the unread region.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int HDR_BYTES = 6;
  localparam int OK_BIT    = 7;

  typedef enum logic [1:0] {WS_IDLE, WS_BODY, WS_HDR} wstate_e;

  // a + n wrapped into [first, last]; n must be smaller than the ring size
  function automatic logic [16:0] ring_add(input logic [16:0] a, input logic [16:0] n,
                                           input logic [16:0] first, input logic [16:0] last);
    logic [17:0] s;
    s = {1'b0, a} + {1'b0, n};
    if (s > {1'b0, last}) s = s - ({1'b0, last} - {1'b0, first} + 18'd1);
    return s[16:0];
  endfunction
endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic [AW-1:0] wr,
  input  logic [AW-1:0] rd,
  output logic [AW:0]   free
);
  logic [AW:0] ring_n;

  always_comb begin
    ring_n = {1'b0, last} - {1'b0, first} + 1'b1;
    if (rd > wr) free = {1'b0, rd} - {1'b0, wr} - 1'b1;
    else         free = {1'b0, rd} + ring_n - {1'b0, wr} - 1'b1;
  end
endmodule

// File: rtl/rxring_count.sv
module rxring_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      case ({inc, dec})
        2'b10:   if (count != MAXC) count <= count + 1'b1;
        2'b01:   if (count != '0)   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic [AW:0]   free,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          s_err,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic          commit,
  output logic          overflow
);
  wstate_e       state;
  logic [AW-1:0] cur;
  logic [15:0]   cnt;
  logic          drop_f, err_f;
  logic [2:0]    idx;
  logic [AW-1:0] next_q;
  logic [15:0]   len_q, st_q;

  logic          take, first_byte, drop_eff, fits_byte, tot_fits, err_all;
  logic [15:0]   cnt_eff, len_now;
  logic [AW-1:0] cur_eff;
  logic [17:0]   need, tot;
  logic [7:0]    hdr_byte;

  always_comb begin
    s_ready    = (state != WS_HDR);
    first_byte = (state == WS_IDLE);
    take       = s_valid && s_ready && (state == WS_BODY || s_sof);
    cnt_eff    = first_byte ? 16'd0 : cnt;
    cur_eff    = first_byte ? AW'(ring_add(17'(wr_ptr), 17'(HDR_BYTES), 17'(first), 17'(last))) : cur;
    drop_eff   = first_byte ? 1'b0 : drop_f;
    err_all    = (first_byte ? 1'b0 : err_f) | s_err;
    len_now    = cnt_eff + 16'd1;
    need       = 18'(HDR_BYTES) + 18'(cnt_eff) + 18'd1;
    tot        = need + {17'd0, need[0]};
    fits_byte  = need <= 18'(free);
    tot_fits   = tot <= 18'(free);
    commit     = (state == WS_HDR) && (idx == 3'd5);
    case (idx)
      3'd0:    hdr_byte = 8'(16'(next_q));
      3'd1:    hdr_byte = 8'(16'(next_q) >> 8);
      3'd2:    hdr_byte = len_q[7:0];
      3'd3:    hdr_byte = len_q[15:8];
      3'd4:    hdr_byte = st_q[7:0];
      default: hdr_byte = st_q[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      cur       <= first;
      cnt       <= '0;
      drop_f    <= 1'b0;
      err_f     <= 1'b0;
      idx       <= '0;
      next_q    <= first;
      len_q     <= '0;
      st_q      <= '0;
      wr_ptr    <= first;
      overflow  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= first;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (state == WS_HDR) begin
        mem_we    <= 1'b1;
        mem_addr  <= AW'(ring_add(17'(wr_ptr), 17'(idx), 17'(first), 17'(last)));
        mem_wdata <= hdr_byte;
        idx       <= idx + 3'd1;
        if (idx == 3'd5) begin
          wr_ptr <= next_q;
          idx    <= '0;
          state  <= WS_IDLE;
        end
      end else if (take) begin
        cnt <= len_now;
        if (!drop_eff && fits_byte) begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_eff;
          mem_wdata <= s_data;
          cur       <= AW'(ring_add(17'(cur_eff), 17'd1, 17'(first), 17'(last)));
        end else begin
          cur <= cur_eff;
        end
        drop_f <= drop_eff | ~fits_byte;
        err_f  <= err_all;
        if (s_eof) begin
          if (drop_eff || !fits_byte || !tot_fits) begin
            overflow <= 1'b1;
            state    <= WS_IDLE;
          end else begin
            next_q <= AW'(ring_add(17'(wr_ptr), 17'(tot), 17'(first), 17'(last)));
            len_q  <= len_now;
            st_q   <= 16'(!err_all) << OK_BIT;
            idx    <= '0;
            state  <= WS_HDR;
          end
        end else begin
          state <= WS_BODY;
        end
      end
    end
  end
endmodule

// File: rtl/rxring_buffer_mgr.sv
module rxring_buffer_mgr #(
  parameter int AW    = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cfg_start,
  input  logic [AW-1:0]    cfg_end,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_sof,
  input  logic             s_eof,
  input  logic             s_err,
  input  logic             host_rd_we,
  input  logic [AW-1:0]    host_rd_ptr,
  input  logic             host_pkt_dec,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [AW-1:0]    wr_ptr,
  output logic [CNT_W-1:0] pkt_count,
  output logic             overflow
);
  logic [AW-1:0] rd_q;
  logic [AW:0]   free;
  logic          commit;

  always_ff @(posedge clk) begin
    if (!rst_n)          rd_q <= cfg_start;
    else if (host_rd_we) rd_q <= host_rd_ptr;
  end

  rxring_space #(.AW(AW)) u_space (
    .first(cfg_start), .last(cfg_end), .wr(wr_ptr), .rd(rd_q), .free(free)
  );

  rxring_writer #(.AW(AW)) u_writer (
    .clk(clk), .rst_n(rst_n), .first(cfg_start), .last(cfg_end), .free(free),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
    .s_eof(s_eof), .s_err(s_err), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .commit(commit), .overflow(overflow)
  );

  rxring_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(commit), .dec(host_pkt_dec), .count(pkt_count)
  );
endmodule

// File: rtl/rxring_checks.sv
module rxring_checks #(
  parameter int AW    = 10,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    cfg_start,
  input logic [AW-1:0]    cfg_end,
  input logic             s_ready,
  input logic             host_pkt_dec,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [AW-1:0]    wr_ptr,
  input logic [CNT_W-1:0] pkt_count,
  input logic             overflow
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
  logic [AW-1:0] wr_off;
  assign wr_off = wr_ptr - cfg_start;

  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= cfg_start && mem_addr <= cfg_end)); // R2

  AST_WR_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> (wr_off[0] == 1'b0)); // R5

  AST_HDR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> mem_we); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == $past(pkt_count)) || (pkt_count == $past(pkt_count) + 1'b1) ||
    (pkt_count == $past(pkt_count) - 1'b1)); // R6

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == MAXC && !host_pkt_dec) |=> (pkt_count == MAXC)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
endmodule

bind rxring_buffer_mgr rxring_checks #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
  .s_ready(s_ready), .host_pkt_dec(host_pkt_dec), .mem_we(mem_we),
  .mem_addr(mem_addr), .wr_ptr(wr_ptr), .pkt_count(pkt_count), .overflow(overflow)
);

// File: tb/test_rxring_buffer_mgr.sv
module test_rxring_buffer_mgr;
  localparam int AW = 10;
  localparam int START = 100;
  localparam int LAST = 355;
  localparam int N = LAST - START + 1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_start = AW'(START), cfg_end = AW'(LAST);
  logic s_valid = 0, s_ready, s_sof = 0, s_eof = 0, s_err = 0;
  logic [7:0] s_data = 0;
  logic host_rd_we = 0, host_pkt_dec = 0;
  logic [AW-1:0] host_rd_ptr = 0;
  logic mem_we;
  logic [AW-1:0] mem_addr, wr_ptr;
  logic [7:0] mem_wdata;
  logic [7:0] pkt_count;
  logic overflow;

  always #5 clk = ~clk;

  rxring_buffer_mgr #(.AW(AW), .CNT_W(8)) i_rxring_buffer_mgr (.*);

  logic [7:0] mem [0:(1<<AW)-1];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int tests = 0, fails = 0;
  int exp_wr = START, exp_rd = START, exp_cnt = 0;
  int q [0:511];
  int qh = 0, qt = 0;
  int bad_ring = 0, bad_unread = 0, wraps = 0;
  logic [7:0] pay [0:255];

  function automatic int f_add(int a, int n);
    return (a + n > LAST) ? a + n - N : a + n;
  endfunction
  function automatic int f_free(int rd, int wr);
    return (rd > wr) ? rd - wr - 1 : rd + N - wr - 1;
  endfunction
  function automatic int f_pad(int x);
    return x + (x & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write monitor: bounds and unread region
  always @(negedge clk) if (rst_n && mem_we) begin
    int a, off, used;
    a = int'(mem_addr);
    if (a < START || a > LAST) bad_ring++;
    off  = (a - exp_rd + N) % N;
    used = (exp_wr - exp_rd + N) % N;
    if (a >= START && a <= LAST && off < used) bad_unread++;
  end

  task automatic put_byte(logic [7:0] d, bit sof, bit eof, bit err);
    bit r;
    @(negedge clk);
    s_valid = 1; s_data = d; s_sof = sof; s_eof = eof; s_err = err;
    #1 r = s_ready;
    while (!r) begin @(negedge clk); #1 r = s_ready; end
    @(posedge clk);
  endtask

  // timing: 0 = plain, 1 = header window check, 2 = also decrement on commit edge
  task automatic send_frame(int len, bit err, int timing);
    int tot, fr, nxt, base, mism, c0;
    fr = f_free(exp_rd, exp_wr);
    tot = f_pad(6 + len);
    base = exp_wr;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      if ($urandom % 4 == 0) begin @(negedge clk); s_valid = 0; end
      put_byte(pay[i], i == 0, i == len - 1, err && (i == len - 1));
    end
    c0 = int'(pkt_count);
    if (timing != 0 && tot <= fr) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        s_valid = 0;
        chk(s_ready == 0 && int'(wr_ptr) == base, "R5 header window", int'(wr_ptr), base);
        if (k == 5 && timing == 2) host_pkt_dec = 1;
      end
      @(negedge clk);
      host_pkt_dec = 0;
      chk(s_ready == 1 && int'(wr_ptr) == f_add(base, tot), "R5 pointer on sixth edge",
          int'(wr_ptr), f_add(base, tot));
      if (timing == 2) begin
        chk(int'(pkt_count) == c0, "R6 inc and dec together", int'(pkt_count), c0);
        exp_cnt = exp_cnt - 1;
      end
    end
    @(negedge clk); s_valid = 0;
    repeat (8) @(negedge clk);
    if (tot <= fr) begin
      nxt = f_add(base, tot);
      mism = 0;
      if (int'(mem[f_add(base,0)]) != (nxt & 255)) mism++;
      if (int'(mem[f_add(base,1)]) != (nxt >> 8)) mism++;
      if (int'(mem[f_add(base,2)]) != (len & 255)) mism++;
      if (int'(mem[f_add(base,3)]) != (len >> 8)) mism++;
      if (mem[f_add(base,4)] != (err ? 8'h00 : 8'h80)) mism++;
      if (mem[f_add(base,5)] != 8'h00) mism++;
      for (int i = 0; i < len; i++) if (mem[f_add(base, 6 + i)] != pay[i]) mism++;
      if (base + 6 + len - 1 > LAST) begin
        wraps++;
        chk(mism == 0, "R1 wrapped frame contents", mism, 0);
      end else chk(mism == 0, "R3 frame layout", mism, 0);
      chk(int'(wr_ptr) == nxt, "R5 next pointer", int'(wr_ptr), nxt);
      exp_wr = nxt;
      if (exp_cnt < 255) exp_cnt++;
      q[qt % 512] = nxt; qt++;
    end else begin
      chk(int'(wr_ptr) == base, "R4 dropped keeps pointer", int'(wr_ptr), base);
      chk(overflow == 1, "R8 overflow on drop", int'(overflow), 1);
    end
    chk(int'(pkt_count) == exp_cnt, "R6 pending count", int'(pkt_count), exp_cnt);
  endtask

  task automatic move_rd(int ptr, bit dec);
    @(negedge clk);
    host_rd_we = 1; host_rd_ptr = AW'(ptr); host_pkt_dec = dec;
    exp_rd = ptr;
    if (dec && exp_cnt > 0) exp_cnt--;
    @(negedge clk);
    host_rd_we = 0; host_pkt_dec = 0;
  endtask

  task automatic consume_one();
    if (qh < qt) begin move_rd(q[qh % 512], 1); qh++; end
  endtask

  task automatic consume_all();
    while (qh < qt) consume_one();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int fr, len;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int'(wr_ptr) == START && pkt_count == 0 && overflow == 0 && s_ready == 1 && mem_we == 0,
        "R11 reset state", int'(wr_ptr), START);

    // stray bytes without start flag
    s_valid = 1; s_sof = 0; s_eof = 1; s_data = 8'h5A;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_we == 0 && int'(wr_ptr) == START, "R10 stray byte ignored", int'(mem_we), 0);
    end
    s_valid = 0;

    send_frame(5, 0, 1);
    send_frame(7, 1, 2);
    send_frame(1, 0, 0);

    // random traffic with host consumption
    for (int n = 0; n < 60; n++) begin
      if ($urandom % 2 == 0) consume_one();
      send_frame(1 + int'($urandom % 80), ($urandom % 5) == 0, 0);
    end
    consume_all();
    chk(wraps > 0, "R1 wrap exercised", wraps, 1);

    // boundary: one byte too many is dropped
    fr = f_free(exp_rd, exp_wr);
    send_frame(fr - 5, 0, 0);
    chk(overflow == 1 && int'(wr_ptr) == exp_wr, "R4 boundary drop", int'(overflow), 1);
    // exact fit stored
    len = fr - 7;
    send_frame(len, 0, 0);
    chk(int'(wr_ptr) == exp_wr && f_free(exp_rd, exp_wr) == 1, "R4 exact fit stored",
        f_free(exp_rd, exp_wr), 1);
    // ring now full: small frame dropped
    send_frame(1, 0, 0);
    chk(overflow == 1, "R8 overflow stays set", int'(overflow), 1);
    // host frees space; same frame now fits
    consume_all();
    send_frame(1, 0, 0);
    chk(int'(wr_ptr) == exp_wr && exp_cnt == 1, "R9 freed space reused", int'(wr_ptr), exp_wr);
    consume_all();
    move_rd(exp_rd, 1);
    chk(pkt_count == 0, "R6 decrement at zero", int'(pkt_count), 0);

    // saturation: move read pointer without decrementing
    for (int n = 0; n < 262; n++) begin
      send_frame(2, 0, 0);
      move_rd(exp_wr, 0);
      qh = qt;
    end
    chk(pkt_count == 8'd255, "R7 count saturates", int'(pkt_count), 255);

    chk(bad_ring == 0, "R2 writes inside ring", bad_ring, 0);
    chk(bad_unread == 0, "R4 unread bytes untouched", bad_unread, 0);
    finish_run();
  end
endmodule